// File: doc/BRIEF.md
# Interrupt Steering Aggregator

This block gathers a parameterised number of level-sensitive interrupt inputs (a multiple of 32, at most 512) and folds them onto a few output interrupt lines. Every 64 inputs form one group, and each group drives one line per output channel. A single control register picks which channel carries the steered interrupts. Every other channel stays silent.

Software reaches the block through a simple 32-bit register port with a chip select, a write strobe, a byte address and write data. Per-input enable bits gate the inputs. A software-owned bank of force bits can make any input pending. Read-only status words show the gated pending bits 32 at a time, so a handler can scan one group with two reads. The words of every per-input bank are laid out in reverse: the highest-numbered inputs sit at the lowest address of that bank. With R = N_IN/32, the banks start at byte offsets that scale with R.

A two-state read engine returns read data one cycle after the request. Its states are `ST_IDLE` (no data on the port) and `ST_RESP` (`rvalid_o` high). A read request moves either state to `ST_RESP`. Any cycle without a read request moves either state to `ST_IDLE`.

Top module: `irqs_steer`

## Requirements
- R1: After reset all registers are zero. `irq_o` is all low, and reads of control, enable, status and group status words return zero.
- R2: Input i belongs to bank word n = R-1-floor(i/32), at bit i mod 32. Enable word n sits at byte offset 4+4n and reads back as written. An input whose enable bit is 0 contributes nothing to status or outputs.
- R3: Force word n sits at byte offset 4R+4+4n. A write replaces all 32 stored force bits of that word, and the word reads back as written.
- R4: Status word n sits at byte offset 8R+4+4n. Each bit reads (input level OR force bit) AND enable bit. Writes to status words have no effect.
- R5: Output line c*G+g, with G = ceil(N_IN/64), is high exactly when the control register equals a single bit c, at least one status bit among inputs 64g..64g+63 is set, and quiet bit g is clear. The line follows the input level with no latching.
- R6: The control register sits at offset 0x0 and keeps its low N_CHAN bits. The upper bits read as zero. When its value is zero or has more than one bit set, every output line is low.
- R7: The quiet register sits at byte offset 12R+4 and keeps G bits. Setting bit g holds every output line of group g low, and leaves status words and group status unchanged.
- R8: The group status register sits at byte offset 12R+8 and is read-only. Bit g is the OR of all status bits of group g.
- R9: Reads of unmapped or non-word-aligned addresses return zero. Writes to them change no register and no output.
- R10: `rvalid_o` is high in exactly the cycle after each accepted read (`cs_i` high, `we_i` low) and carries that read's data. It is low after writes and after idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| irq_i | input | N_IN | Level-sensitive interrupt inputs |
| cs_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid with rvalid_o |
| rvalid_o | output | 1 | Read data valid |
| irq_o | output | N_CHAN*ceil(N_IN/64) | Steered output lines, index channel*groups+group |

## Verification
Two paths can act on the same input at the same time: the live input level and the software force bit. The bench holds an input high while its force bit is set, then clears the force word in a write. The output line and the status word must stay asserted until the input itself falls. The line and the status word are then expected to drop in the same cycle. A second overlap is the quiet mask against a pending, enabled input. The bench checks that the line drops while both the status word and the group status bit still report the pending input.

// File: rtl/irqs_pkg.sv
package irqs_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } rd_state_e;

    function automatic int grp_count(input int n_in);
        return (n_in + 63) / 64;
    endfunction

endpackage

// File: rtl/irqs_fold.sv
module irqs_fold #(
    parameter int N_IN   = 128,
    parameter int N_CHAN = 2,
    localparam int G     = irqs_pkg::grp_count(N_IN)
) (
    input  logic [N_IN-1:0]     irq_i,
    input  logic [N_IN-1:0]     en_i,
    input  logic [N_IN-1:0]     force_i,
    input  logic [N_CHAN-1:0]   ctrl_i,
    input  logic [G-1:0]        quiet_i,
    output logic [N_IN-1:0]     stat_o,
    output logic [G-1:0]        grp_any_o,
    output logic [N_CHAN*G-1:0] irq_o
);

    logic [G*64-1:0] stat_pad;

    assign stat_o   = (irq_i | force_i) & en_i;
    assign stat_pad = (G*64)'(stat_o);

    for (genvar g = 0; g < G; g++) begin : g_grp
        assign grp_any_o[g] = |stat_pad[g*64 +: 64];
    end

    for (genvar c = 0; c < N_CHAN; c++) begin : g_chan
        logic sel;
        assign sel = (ctrl_i == (N_CHAN'(1) << c));
        for (genvar g = 0; g < G; g++) begin : g_line
            assign irq_o[c*G+g] = sel & grp_any_o[g] & ~quiet_i[g];
        end
    end

endmodule

// File: rtl/irqs_regs.sv
module irqs_regs #(
    parameter int N_IN   = 128,
    parameter int N_CHAN = 2,
    parameter int ADDR_W = 8,
    localparam int R     = N_IN / 32,
    localparam int G     = irqs_pkg::grp_count(N_IN),
    localparam int QUIET_WA = 3*R + 1,
    localparam int GSTAT_WA = 3*R + 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cs_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [31:0]       wdata_i,
    input  logic [N_IN-1:0]   stat_i,
    input  logic [G-1:0]      grp_any_i,
    output logic [N_IN-1:0]   en_o,
    output logic [N_IN-1:0]   force_o,
    output logic [N_CHAN-1:0] ctrl_o,
    output logic [G-1:0]      quiet_o,
    output logic [31:0]       rdata_o,
    output logic              rvalid_o
);
    import irqs_pkg::*;

    logic [31:0] wa;
    logic        aligned;
    logic        wr_hit;
    logic [31:0] rd_word;
    logic [31:0] rdata_q;
    rd_state_e   state_q, state_d;

    assign wa      = 32'(addr_i[ADDR_W-1:2]);
    assign aligned = (addr_i[1:0] == 2'b00);
    assign wr_hit  = cs_i & we_i & aligned;

    // register writes
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            en_o    <= '0;
            force_o <= '0;
            ctrl_o  <= '0;
            quiet_o <= '0;
        end else if (wr_hit) begin
            if (wa == 32'd0)
                ctrl_o <= wdata_i[N_CHAN-1:0];
            if (wa == 32'(QUIET_WA))
                quiet_o <= wdata_i[G-1:0];
            for (int n = 0; n < R; n++) begin
                if (wa == 32'(n + 1))
                    en_o[(R-1-n)*32 +: 32] <= wdata_i;
                if (wa == 32'(R + 1 + n))
                    force_o[(R-1-n)*32 +: 32] <= wdata_i;
            end
        end
    end

    // read decode
    always_comb begin
        rd_word = '0;
        if (aligned) begin
            if (wa == 32'd0)
                rd_word = 32'(ctrl_o);
            if (wa == 32'(QUIET_WA))
                rd_word = 32'(quiet_o);
            if (wa == 32'(GSTAT_WA))
                rd_word = 32'(grp_any_i);
            for (int n = 0; n < R; n++) begin
                if (wa == 32'(n + 1))
                    rd_word = en_o[(R-1-n)*32 +: 32];
                if (wa == 32'(R + 1 + n))
                    rd_word = force_o[(R-1-n)*32 +: 32];
                if (wa == 32'(2*R + 1 + n))
                    rd_word = stat_i[(R-1-n)*32 +: 32];
            end
        end
    end

    // read engine: next state
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE: state_d = (cs_i && !we_i) ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = (cs_i && !we_i) ? ST_RESP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // read engine: state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_IDLE;
        else         state_q <= state_d;
    end

    // read engine: data capture
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                rdata_q <= '0;
        else if (cs_i && !we_i)     rdata_q <= rd_word;
    end

    // read engine: outputs
    always_comb begin
        rvalid_o = (state_q == ST_RESP);
        rdata_o  = rvalid_o ? rdata_q : '0;
    end

endmodule

// File: rtl/irqs_steer.sv
module irqs_steer #(
    parameter int N_IN   = 128,
    parameter int N_CHAN = 2,
    parameter int ADDR_W = 8,
    localparam int G     = irqs_pkg::grp_count(N_IN)
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [N_IN-1:0]     irq_i,
    input  logic                cs_i,
    input  logic                we_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [31:0]         wdata_i,
    output logic [31:0]         rdata_o,
    output logic                rvalid_o,
    output logic [N_CHAN*G-1:0] irq_o
);

    logic [N_IN-1:0]   en_q;
    logic [N_IN-1:0]   force_q;
    logic [N_CHAN-1:0] ctrl_q;
    logic [G-1:0]      quiet_q;
    logic [N_IN-1:0]   stat;
    logic [G-1:0]      grp_any;

    irqs_regs #(.N_IN(N_IN), .N_CHAN(N_CHAN), .ADDR_W(ADDR_W)) u_regs (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .cs_i      (cs_i),
        .we_i      (we_i),
        .addr_i    (addr_i),
        .wdata_i   (wdata_i),
        .stat_i    (stat),
        .grp_any_i (grp_any),
        .en_o      (en_q),
        .force_o   (force_q),
        .ctrl_o    (ctrl_q),
        .quiet_o   (quiet_q),
        .rdata_o   (rdata_o),
        .rvalid_o  (rvalid_o)
    );

    irqs_fold #(.N_IN(N_IN), .N_CHAN(N_CHAN)) u_fold (
        .irq_i     (irq_i),
        .en_i      (en_q),
        .force_i   (force_q),
        .ctrl_i    (ctrl_q),
        .quiet_i   (quiet_q),
        .stat_o    (stat),
        .grp_any_o (grp_any),
        .irq_o     (irq_o)
    );

endmodule

// File: rtl/irqs_steer_chk.sv
module irqs_steer_chk #(
    parameter int N_IN   = 128,
    parameter int N_CHAN = 2,
    parameter int ADDR_W = 8,
    localparam int R     = N_IN / 32,
    localparam int G     = irqs_pkg::grp_count(N_IN)
) (
    input logic                clk_i,
    input logic                rst_ni,
    input logic                cs_i,
    input logic                we_i,
    input logic [ADDR_W-1:0]   addr_i,
    input logic [31:0]         wdata_i,
    input logic                rvalid_o,
    input logic [N_CHAN*G-1:0] irq_o,
    input logic [N_CHAN-1:0]   ctrl_q,
    input logic [G-1:0]        quiet_q,
    input logic [G-1:0]        grp_any,
    input logic [N_IN-1:0]     force_q
);

    logic [31:0] wa;
    logic        force_wr;
    logic [31:0] base_q;

    assign wa       = 32'(addr_i[ADDR_W-1:2]);
    assign force_wr = cs_i && we_i && (addr_i[1:0] == 2'b00)
                      && (wa >= 32'(R + 1)) && (wa <= 32'(2*R));

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       base_q <= '0;
        else if (force_wr) base_q <= 32'(R - 1) - (wa - 32'(R + 1));
    end

    p_rvalid_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cs_i && !we_i) |=> rvalid_o);

    p_no_rvalid_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(cs_i && !we_i) |=> !rvalid_o);

    p_single_chan_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|irq_o) |-> ($countones(ctrl_q) == 1));

    p_force_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        force_wr |=> (force_q[base_q*32 +: 32] == $past(wdata_i)));

    for (genvar c = 0; c < N_CHAN; c++) begin : g_c
        for (genvar g = 0; g < G; g++) begin : g_g
            p_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
                quiet_q[g] |-> !irq_o[c*G+g]);
            p_line_grp_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
                irq_o[c*G+g] |-> grp_any[g]);
        end
    end

endmodule

bind irqs_steer irqs_steer_chk #(.N_IN(N_IN), .N_CHAN(N_CHAN), .ADDR_W(ADDR_W)) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cs_i     (cs_i),
    .we_i     (we_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .rvalid_o (rvalid_o),
    .irq_o    (irq_o),
    .ctrl_q   (ctrl_q),
    .quiet_q  (quiet_q),
    .grp_any  (grp_any),
    .force_q  (force_q)
);

// File: tb/tb_irqs_steer.sv
module tb_irqs_steer;

    localparam int N_IN   = 128;
    localparam int N_CHAN = 2;
    localparam int ADDR_W = 8;
    localparam int G      = 2;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [N_IN-1:0]     irq_in = '0;
    logic                cs = 1'b0;
    logic                we = 1'b0;
    logic [ADDR_W-1:0]   addr = '0;
    logic [31:0]         wdata = '0;
    logic [31:0]         rdata_o;
    logic                rvalid_o;
    logic [N_CHAN*G-1:0] irq_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    irqs_steer #(.N_IN(N_IN), .N_CHAN(N_CHAN), .ADDR_W(ADDR_W)) dut (
        .clk_i    (clk),
        .rst_ni   (rst_n),
        .irq_i    (irq_in),
        .cs_i     (cs),
        .we_i     (we),
        .addr_i   (addr),
        .wdata_i  (wdata),
        .rdata_o  (rdata_o),
        .rvalid_o (rvalid_o),
        .irq_o    (irq_o)
    );

    // monitor: pops expected read data as responses appear
    always @(negedge clk) begin
        if (rst_n && rvalid_o) begin
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R10 unexpected rvalid: actual data %h expected no response", rdata_o);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (rdata_o !== e) begin
                    fails++;
                    $display("FAIL %s read: actual %h expected %h", t, rdata_o, e);
                end
            end
        end
    end

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        cs = 1'b1; we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        cs = 1'b0; we = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, input logic [31:0] e, input string t);
        @(negedge clk);
        cs = 1'b1; we = 1'b0; addr = a;
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        cs = 1'b0;
    endtask

    task automatic chk_out(input logic [N_CHAN*G-1:0] e, input string t);
        #1;
        checks++;
        if (irq_o !== e) begin
            fails++;
            $display("FAIL %s irq_o: actual %b expected %b", t, irq_o, e);
        end
    endtask

    task automatic set_in(input int k, input logic v);
        @(negedge clk);
        irq_in[k] = v;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk_out(4'b0000, "R1");
        rd(8'h00, 32'h0, "R1 ctrl");
        rd(8'h04, 32'h0, "R1 enable word 0");
        rd(8'h30, 32'h0, "R1 status word 3");
        rd(8'h38, 32'h0, "R1 group status");

        // R2 reversed enable layout: input 0 lives in word 3 at 0x10
        wr(8'h10, 32'h0000_0001);
        rd(8'h10, 32'h0000_0001, "R2 enable word 3");
        rd(8'h04, 32'h0, "R2 enable word 0");

        // R4 status, R6 zero control keeps outputs low
        set_in(0, 1'b1);
        rd(8'h30, 32'h0000_0001, "R4 status word 3");
        chk_out(4'b0000, "R6 ctrl zero");

        // R5 steering to channel 0 then channel 1
        wr(8'h00, 32'h1);
        chk_out(4'b0001, "R5 chan0 grp0");
        rd(8'h38, 32'h1, "R8 group status grp0");
        wr(8'h00, 32'h2);
        chk_out(4'b0100, "R5 chan1 grp0");

        // R6 non-one-hot control, upper bits dropped
        wr(8'h00, 32'h3);
        chk_out(4'b0000, "R6 two bits");
        wr(8'h00, 32'hFFFF_FFFF);
        rd(8'h00, 32'h3, "R6 ctrl readback");
        chk_out(4'b0000, "R6 all bits");

        // R5 level following
        wr(8'h00, 32'h1);
        chk_out(4'b0001, "R5 level high");
        set_in(0, 1'b0);
        chk_out(4'b0000, "R5 level low");
        rd(8'h30, 32'h0, "R4 status drops");

        // R3 force bank: input 127 is word 0 bit 31
        wr(8'h04, 32'h8000_0000);
        wr(8'h14, 32'h8000_0000);
        chk_out(4'b0010, "R3 force grp1");
        rd(8'h14, 32'h8000_0000, "R3 force readback");
        rd(8'h24, 32'h8000_0000, "R4 status forced");
        rd(8'h38, 32'h2, "R8 group status grp1");

        // overlap: input and force on same bit, force cleared
        set_in(127, 1'b1);
        wr(8'h14, 32'h0);
        chk_out(4'b0010, "R3 input holds after force clear");
        rd(8'h14, 32'h0, "R3 force replaced");
        rd(8'h24, 32'h8000_0000, "R4 status input only");
        set_in(127, 1'b0);
        chk_out(4'b0000, "R5 drop after input falls");

        // R4 status is read-only
        wr(8'h24, 32'hFFFF_FFFF);
        rd(8'h24, 32'h0, "R4 status write ignored");
        rd(8'h14, 32'h0, "R4 force untouched");
        chk_out(4'b0000, "R4 no output after status write");

        // R2 gating: input 69 is word 1 (0x08) bit 5
        set_in(69, 1'b1);
        chk_out(4'b0000, "R2 masked input");
        rd(8'h28, 32'h0, "R2 masked status");
        wr(8'h08, 32'h0000_0020);
        chk_out(4'b0010, "R2 enabled input");
        rd(8'h28, 32'h0000_0020, "R2 enabled status");

        // R7 quiet register
        wr(8'h34, 32'h2);
        chk_out(4'b0000, "R7 quiet grp1");
        rd(8'h28, 32'h0000_0020, "R7 status kept");
        rd(8'h38, 32'h2, "R7 group status kept");
        rd(8'h34, 32'h2, "R7 quiet readback");
        wr(8'h34, 32'h0);
        chk_out(4'b0010, "R7 quiet released");

        // R9 unmapped and misaligned accesses
        wr(8'h3C, 32'hFFFF_FFFF);
        wr(8'h05, 32'hFFFF_FFFF);
        wr(8'h01, 32'h2);
        chk_out(4'b0010, "R9 writes ignored");
        rd(8'h3C, 32'h0, "R9 unmapped read");
        rd(8'hFC, 32'h0, "R9 high unmapped read");
        rd(8'h05, 32'h0, "R9 misaligned read");
        rd(8'h04, 32'h8000_0000, "R9 enable word 0 unchanged");
        rd(8'h00, 32'h1, "R9 ctrl unchanged");

        // R10 all queued responses consumed
        repeat (3) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R10 missing responses: actual %0d pending expected 0", exp_q.size());
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule